// File: doc/BRIEF.md
# Queued-Duty Pulse Width Modulator

A single-channel pulse width modulator driven through a small synchronous register port. A clock divider slows the input clock by a programmable ratio, and a free-running period counter steps once per divided tick. The output is active while the counter is below the active duty sample. Duty samples are queued in a four-word buffer, and one sample is taken for each period. Each sample can be held for a programmable number of consecutive periods before the next one is taken.

Software fills the queue while the block is stopped, or tops it up while it runs. A sample written while the block runs with an empty queue is applied to the comparator at once, in the middle of the current period. The output can be normal, inverted or forced low. Sticky event flags report counter rollover, compare match and writes lost to a full queue. A self-clearing soft-reset bit returns every register to its reset value.

Register reads are combinational from `reg_addr`. Writes take effect on the clock edge on which `reg_wr` is high. Register indices are: 0 control, 1 status, 2 duty sample, 3 period, 4 counter.

Top module: `sample_pwm`

## Requirements
- R1: While enabled, the counter (register 4) steps once every prescale+1 clocks, where prescale is control bits [17:6]. It returns to 0 after value period+1, so one output period lasts (period+2)*(prescale+1) clocks. The count starts at 0 on the edge that sets the enable bit.
- R2: A period register value of 0xFFFF gives the same period as 0xFFFE: the counter tops out at 0xFFFF and then wraps to 0. The period register still reads back the written value.
- R3: Output mode is control bits [5:4]. In mode 0 the output is 1 while counter < active sample. Mode 1 gives the complement of mode 0. Modes 2 and 3 hold the output at 0.
- R4: While the enable bit (control bit 0) is 0, the output is 0 in every mode, the counter reads 0, and the sample register reads 0.
- R5: The queue holds 4 samples. Status bits [2:0] give the number of samples held (0 to 4), and status bit 3 is 1 whenever the queue is empty.
- R6: A sample written while enabled and with an empty queue becomes the active sample on that same edge. The output uses it from the next cycle, and the sample register reads it back.
- R7: A sample written while disabled, or while the queue holds data, is queued. The edge that sets the enable bit moves the oldest queued sample to the active sample. A period wrap does the same once the current sample has served its repeat count.
- R8: Control bits [3:2] = 0, 1, 2, 3 make each sample serve 1, 2, 4 or 8 consecutive periods. The last sample stays active while the queue is empty.
- R9: A sample write to a full queue is dropped, the queue keeps its contents, and status bit 6 is set.
- R10: Status bit 4 is set when the counter wraps to 0. Status bit 5 is set on the step that brings the counter to the active sample value. Writing 1 to status bits 4, 5 or 6 clears that flag.
- R11: Writing control with bit 1 set makes bit 1 read back as 1 for one cycle. After that cycle, all registers, the queue and all flags are at their reset values, and bit 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 status, 2 sample, 3 period, 4 counter) |
| reg_wdata | input | 18 | Write data |
| reg_rdata | output | 18 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 12-bit prescale field and a four-word queue. With these values every point of a small grid can be swept. The grid covers periods 0 to 4, prescale 0 to 2, each duty from 0 to past the period length, and all three output behaviours, with the expected high time computed from the period formula. The small queue depth lets every repeat encoding be run from a full queue through to the drain. The full-width counter makes one complete 0xFFFF period of 65536 clocks short enough to check the clamp directly.

// File: rtl/spwm_pkg.sv
// Package: register indices, control/status bit positions and output modes
// shared by the queued-duty PWM modules. Assumes a 3-bit register index.
package spwm_pkg;
    localparam int ADDR_W   = 3;
    localparam int EN_BIT   = 0;
    localparam int SRST_BIT = 1;
    localparam int REP_LSB  = 2;
    localparam int MODE_LSB = 4;
    localparam int PRE_LSB  = 6;
    localparam int REP_CNT_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_STAT   = 3'd1,
        A_SAMPLE = 3'd2,
        A_PERIOD = 3'd3,
        A_COUNT  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        OUT_NORMAL = 2'd0,
        OUT_INVERT = 2'd1,
        OUT_OFF    = 2'd2,
        OUT_OFF2   = 2'd3
    } out_mode_e;
endpackage

// File: rtl/spwm_prescaler.sv
// Clock divider: asserts tick once every ratio+1 cycles while run is high.
// Assumes: ratio may change at any time; a lowered ratio ends the current
// count at once. Held at zero while run is low.
module spwm_prescaler #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] ratio,
    output logic         tick
);
    logic [W-1:0] pre_cnt;

    assign tick = run && (pre_cnt >= ratio);

    // Divider count: restarts after each tick, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R1: every tick starts a fresh divided interval.
    p_tick_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_cnt == '0));
endmodule

// File: rtl/spwm_period_counter.sv
// Period counter: steps on each tick and wraps to 0 after reaching limit.
// Assumes: limit is period+1 already clamped by the caller; clear holds 0.
module spwm_period_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic [W-1:0] next_count,
    output logic         wrap
);
    logic at_top;

    assign at_top     = (count >= limit);
    assign next_count = at_top ? '0 : count + 1'b1;
    assign wrap       = tick && !clear && at_top;

    // Counter register: cleared when stopped, advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (tick) begin
            count <= next_count;
        end
    end

    // R1: no tick and no clear leaves the count unchanged.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(count));
    // R1: a wrap always returns the count to zero.
    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));
endmodule

// File: rtl/spwm_sample_fifo.sv
// Duty sample queue: circular buffer of DEPTH words with a level count.
// Assumes: DEPTH is a power of two; a push while full is dropped; push and
// pop in the same cycle are both honoured when legal.
module spwm_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // One storage word per entry, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (push_ok && (wr_ptr == PTR_W'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R5: level never exceeds the depth.
    p_level_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    // R9: a push into a full queue without a pop leaves it full.
    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
endmodule

// File: rtl/sample_pwm.sv
// Queued-duty PWM top: register file, duty sample selection with repeat
// counting, event flags and output shaping. Assumes one register access per
// cycle, combinational read data, and a synchronous active-low reset.
module sample_pwm import spwm_pkg::*; #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 12,
    parameter int DEPTH = 4,
    localparam int DATA_W = PRE_LSB + PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);
    localparam int LVL_W     = $clog2(DEPTH + 1);
    localparam int F_EMPTY   = LVL_W;
    localparam int F_ROV     = LVL_W + 1;
    localparam int F_CMP     = LVL_W + 2;
    localparam int F_WERR    = LVL_W + 3;

    logic                 en, srst_q;
    logic [1:0]           rep_sel;
    out_mode_e            mode;
    logic [PRE_W-1:0]     prescale;
    logic [CNT_W-1:0]     period, per_eff, limit;
    logic [CNT_W-1:0]     active;
    logic [REP_CNT_W-1:0] rep_cnt, reps_m1;
    logic                 flag_rov, flag_cmp, flag_werr;
    logic                 rst_n_int;
    logic                 ctrl_wr, stat_wr, sample_wr, period_wr;
    logic                 en_rise, direct, push_req, pop, rep_done;
    logic                 tick, wrap, raw;
    logic [CNT_W-1:0]     count, next_count, head;
    logic [LVL_W-1:0]     level;
    logic                 fifo_full, fifo_empty;

    assign rst_n_int = rst_n && !srst_q;
    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
    assign stat_wr   = reg_wr && (reg_addr == A_STAT);
    assign sample_wr = reg_wr && (reg_addr == A_SAMPLE);
    assign period_wr = reg_wr && (reg_addr == A_PERIOD);

    assign per_eff  = (period == '1) ? period - 1'b1 : period;
    assign limit    = per_eff + 1'b1;
    assign reps_m1  = REP_CNT_W'((4'd1 << rep_sel) - 4'd1);
    assign rep_done = (rep_cnt == reps_m1);
    assign en_rise  = ctrl_wr && reg_wdata[EN_BIT] && !en;
    assign direct   = sample_wr && en && fifo_empty;
    assign push_req = sample_wr && !direct;
    assign pop      = !fifo_empty && (en_rise || (wrap && rep_done));

    spwm_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n_int),
        .run   (en),
        .ratio (prescale),
        .tick  (tick)
    );

    spwm_period_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n_int),
        .clear      (!en),
        .tick       (tick),
        .limit      (limit),
        .count      (count),
        .next_count (next_count),
        .wrap       (wrap)
    );

    spwm_sample_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n_int),
        .push  (push_req),
        .pop   (pop),
        .wdata (reg_wdata[CNT_W-1:0]),
        .head  (head),
        .level (level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Control and period registers; the soft-reset bit lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n_int) begin
            en       <= 1'b0;
            srst_q   <= 1'b0;
            rep_sel  <= '0;
            mode     <= OUT_NORMAL;
            prescale <= '0;
            period   <= '0;
        end else begin
            if (ctrl_wr) begin
                en       <= reg_wdata[EN_BIT];
                srst_q   <= reg_wdata[SRST_BIT];
                rep_sel  <= reg_wdata[REP_LSB +: 2];
                mode     <= out_mode_e'(reg_wdata[MODE_LSB +: 2]);
                prescale <= reg_wdata[PRE_LSB +: PRE_W];
            end
            if (period_wr) period <= reg_wdata[CNT_W-1:0];
        end
    end

    // Active sample selection and per-sample repeat count.
    always_ff @(posedge clk) begin
        if (!rst_n_int) begin
            active  <= '0;
            rep_cnt <= '0;
        end else if (direct) begin
            active  <= reg_wdata[CNT_W-1:0];
            rep_cnt <= '0;
        end else if (pop) begin
            active  <= head;
            rep_cnt <= '0;
        end else if (en_rise) begin
            rep_cnt <= '0;
        end else if (wrap && !rep_done) begin
            rep_cnt <= rep_cnt + 1'b1;
        end
    end

    // Sticky event flags, cleared by writing ones; a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n_int) begin
            flag_rov  <= 1'b0;
            flag_cmp  <= 1'b0;
            flag_werr <= 1'b0;
        end else begin
            flag_rov  <= wrap || (flag_rov && !(stat_wr && reg_wdata[F_ROV]));
            flag_cmp  <= (tick && (next_count == active)) ||
                         (flag_cmp && !(stat_wr && reg_wdata[F_CMP]));
            flag_werr <= (push_req && fifo_full) ||
                         (flag_werr && !(stat_wr && reg_wdata[F_WERR]));
        end
    end

    // Output shaping by mode, forced low while disabled.
    always_comb begin
        raw = (count < active);
        unique case (mode)
            OUT_NORMAL: pwm_out = en && raw;
            OUT_INVERT: pwm_out = en && !raw;
            default:    pwm_out = 1'b0;
        endcase
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[EN_BIT]               = en;
                reg_rdata[SRST_BIT]             = srst_q;
                reg_rdata[REP_LSB +: 2]         = rep_sel;
                reg_rdata[MODE_LSB +: 2]        = mode;
                reg_rdata[PRE_LSB +: PRE_W]     = prescale;
            end
            A_STAT: begin
                reg_rdata[LVL_W-1:0] = level;
                reg_rdata[F_EMPTY]   = fifo_empty;
                reg_rdata[F_ROV]     = flag_rov;
                reg_rdata[F_CMP]     = flag_cmp;
                reg_rdata[F_WERR]    = flag_werr;
            end
            A_SAMPLE: reg_rdata[CNT_W-1:0] = en ? active : '0;
            A_PERIOD: reg_rdata[CNT_W-1:0] = period;
            A_COUNT:  reg_rdata[CNT_W-1:0] = count;
            default:  reg_rdata = '0;
        endcase
    end

    // R4: a disabled block never drives the output high.
    p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out);
    // R11: the soft-reset bit never lasts more than one cycle.
    p_srst_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q);
    // R6: a write into an empty running queue reaches the comparator at once.
    p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && !srst_q) |=> (active == $past(reg_wdata[CNT_W-1:0])));
    // R9: a queued write into a full queue raises the write-error flag.
    p_werr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_full && !srst_q) |=> flag_werr);
endmodule

// File: tb/sample_pwm_bench.sv
// Bench for sample_pwm: sweeps period, prescale, duty and mode, runs every
// repeat encoding from a full queue, and checks flags, clamp and soft reset.
module sample_pwm_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 18;
    localparam logic [2:0] RC = 3'd0, RS = 3'd1, RSMP = 3'd2, RP = 3'd3, RCNT = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              pwm_out;
    int                checks = 0;
    int                errors = 0;

    sample_pwm u_sample_pwm (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ctl(int en, int srst, int rep, int mode, int pre);
        return en | (srst << 1) | (rep << 2) | (mode << 4) | (pre << 6);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d[DATA_W-1:0];
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int v, hi, n, exp_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        rd(RS, v);   chk("R5 reset status", v, 8);
        rd(RC, v);   chk("R4 reset control", v, 0);
        chk("R4 reset output", int'(pwm_out), 0);

        // R4: disabled with inverted mode stays low, sample reads 0
        wr(RSMP, 9);
        wr(RC, ctl(0, 0, 0, 1, 0));
        chk("R4 disabled inverted out", int'(pwm_out), 0);
        rd(RSMP, v); chk("R4 disabled sample read", v, 0);
        rd(RCNT, v); chk("R4 disabled counter", v, 0);
        rd(RS, v);   chk("R7 queued while disabled", v & 7, 1);
        wr(RC, ctl(1, 0, 0, 0, 0));
        wr(RC, 0);

        // R1/R3: sweep mode, prescale, period and duty
        for (int m = 0; m < 3; m++)
            for (int p = 0; p < 3; p++)
                for (int per = 0; per < 5; per++)
                    for (int d = 0; d <= per + 3; d++) begin
                        wr(RP, per);
                        wr(RSMP, d);
                        wr(RC, ctl(1, 0, 0, m, p));
                        n = (per + 2) * (p + 1);
                        hi = 0;
                        for (int i = 0; i < n; i++) begin
                            if (i != 0) @(negedge clk);
                            hi += int'(pwm_out);
                        end
                        exp_hi = ((d < per + 2) ? d : per + 2) * (p + 1);
                        if (m == 1) exp_hi = n - exp_hi;
                        if (m == 2) exp_hi = 0;
                        chk($sformatf("R3 R1 m=%0d p=%0d per=%0d d=%0d", m, p, per, d), hi, exp_hi);
                        wr(RC, 0);
                    end

        // R1: counter readback with prescale 2
        wr(RP, 4); wr(RSMP, 1);
        wr(RC, ctl(1, 0, 0, 0, 2));
        repeat (7) @(negedge clk);
        rd(RCNT, v); chk("R1 counter readback", v, 2);
        wr(RC, 0);

        // R5/R9/R8/R7: fill queue, overflow, then each repeat encoding
        for (int r = 0; r < 4; r++) begin
            wr(RP, 3);
            for (int s = 1; s <= 4; s++) wr(RSMP, s);
            rd(RS, v); chk("R5 full level", v & 15, 4);
            wr(RSMP, 7);
            rd(RS, v);
            chk("R9 overflow flag", (v >> 6) & 1, 1);
            chk("R9 level kept", v & 7, 4);
            wr(RS, 64);
            rd(RS, v); chk("R10 werr cleared", (v >> 6) & 1, 0);
            wr(RC, ctl(1, 0, r, 0, 0));
            for (int k = 0; k < 4 * (1 << r) + 2; k++) begin
                hi = 0;
                for (int i = 0; i < 5; i++) begin
                    if (!(k == 0 && i == 0)) @(negedge clk);
                    hi += int'(pwm_out);
                end
                exp_hi = ((k >> r) < 3 ? (k >> r) : 3) + 1;
                chk($sformatf("R8 R7 rep=%0d period=%0d", r, k), hi, exp_hi);
            end
            wr(RC, 0);
        end

        // R7: write while running with data queued waits for the wrap
        wr(RP, 9);
        wr(RSMP, 7); wr(RSMP, 2);
        wr(RC, ctl(1, 0, 0, 0, 0));
        wr(RSMP, 5);
        rd(RSMP, v); chk("R7 sample deferred", v, 7);
        rd(RS, v);   chk("R7 queue level", v & 7, 2);
        repeat (12) @(negedge clk);
        rd(RSMP, v); chk("R7 sample after wrap", v, 2);
        wr(RC, 0);
        wr(RC, ctl(0, 1, 0, 0, 0));
        @(negedge clk);

        // R6: write into empty queue while running applies mid-period
        wr(RP, 9); wr(RSMP, 8);
        wr(RC, ctl(1, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        chk("R6 high before write", int'(pwm_out), 1);
        wr(RSMP, 2);
        chk("R6 low after write", int'(pwm_out), 0);
        rd(RSMP, v); chk("R6 sample readback", v, 2);
        wr(RC, 0);

        // R10: compare and rollover flags and their clearing
        wr(RS, 112);
        rd(RS, v); chk("R10 flags clear", v, 8);
        wr(RSMP, 5);
        wr(RC, ctl(1, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        rd(RS, v); chk("R10 no compare yet", (v >> 5) & 1, 0);
        @(negedge clk);
        rd(RS, v); chk("R10 compare set", (v >> 5) & 1, 1);
        repeat (5) @(negedge clk);
        rd(RS, v); chk("R10 no rollover yet", (v >> 4) & 1, 0);
        @(negedge clk);
        rd(RS, v); chk("R10 rollover set", (v >> 4) & 1, 1);
        wr(RC, 0);
        wr(RS, 48);
        rd(RS, v); chk("R10 flags cleared by write", v, 8);

        // R2: 0xFFFF behaves as 0xFFFE
        wr(RP, 65535);
        rd(RP, v); chk("R2 period readback", v, 65535);
        wr(RSMP, 0);
        wr(RC, ctl(1, 0, 0, 0, 0));
        repeat (65535) @(negedge clk);
        rd(RCNT, v); chk("R2 counter at top", v, 65535);
        @(negedge clk);
        rd(RCNT, v); chk("R2 counter wrapped", v, 0);

        // R11: soft reset
        wr(RC, ctl(1, 1, 2, 1, 3));
        rd(RC, v); chk("R11 reset bit visible", (v >> 1) & 1, 1);
        @(negedge clk);
        rd(RC, v); chk("R11 control cleared", v, 0);
        rd(RP, v); chk("R11 period cleared", v, 0);
        rd(RS, v); chk("R11 status cleared", v, 8);

        finish_run();
    end
endmodule